// File: doc/BRIEF.md
# Analog Pipeline Cell Controller

This controller drives the addressing of a circular analog sample memory in a detector front end. The memory has 144 cells. The write pointer moves to a new cell on every bunch-crossing clock, so each cell holds a sample for about one lap of the ring. The trigger decision arrives a programmable number of crossings after the sample was taken. When a level-1 accept arrives, the controller locates the cells that were written that many crossings earlier. It reserves five consecutive cells starting there and queues them for digitization.

Reserved cells are withheld from the write pointer, which hops over them until the digitizer reports the event finished. Pending events wait in an eight-entry queue that absorbs trigger bursts. Each queued event carries its first cell and a 12-bit crossing-count tag. Cell addresses leave the queue one per cycle, oldest event first. The latency setting is kept in three voted copies, and each copy is rewritten from the voted value every cycle.

Top module: `pipe_cell_ctrl`

## Requirements
- R1: A synchronous reset clears every reservation and empties the queue. It sets the write cell to 0, the crossing counter to 0 and the latency to 100, and clears both flags.
- R2: When no cell is reserved, the write cell advances by one on every clock and wraps from 143 to 0.
- R3: On an accepted trigger, the first reserved cell is (write cell − latency) mod 144. The write cell and latency used are the register values at the triggering edge. A latency written through `cfg_we`/`cfg_lat` on that same edge applies only to later triggers.
- R4: From the cycle after an event reaches the head of the issue order, `rd_valid` is high for five consecutive cycles. `rd_cell` steps through start, start+1, … start+4 (mod 144). `rd_last` is high only in the fifth cycle. `rd_tag` equals the crossing count (clocks since reset, mod 4096) at the triggering edge.
- R5: The write pointer never lands on a reserved cell. It jumps directly to the next free cell, and this includes cells reserved on the same edge.
- R6: Reserved cells stay reserved until a `rd_done` pulse releases the oldest event whose addresses have all been issued. After that the write pointer visits those cells again.
- R7: Up to eight events may be held at once. Their addresses are issued strictly in trigger order, and a second event waits until the first has issued all five of its cells.
- R8: A trigger is dropped and the sticky `ovf` flag is set in two cases: eight events are already held, or any cell of the new window is already reserved.
- R9: A `rd_done` pulse when no fully issued event is held sets the sticky `err` flag and releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load strobe for the latency setting |
| cfg_lat | input | 7 | New latency in crossings |
| l1a | input | 1 | Level-1 accept, one pulse per triggered crossing |
| rd_done | input | 1 | Digitizer finished the oldest issued event |
| wr_cell | output | 8 | Cell written this crossing |
| rd_valid | output | 1 | `rd_cell` holds an address to digitize |
| rd_cell | output | 8 | Cell to digitize |
| rd_tag | output | 12 | Crossing-count tag of the event being read |
| rd_last | output | 1 | Final cell of the current event |
| ovf | output | 1 | Sticky: a trigger was dropped |
| err | output | 1 | Sticky: unmatched readout-done |

## Verification
The window mapping is tried with latency and trigger-time pairs whose windows fall in the middle of the ring, straddle the 143-to-0 wrap, or sit at a latency of 127. One pair also lets the crossing tag wrap past 4095, so an error in the modulo of the cell address shows up separately from an error in the tag. A zero latency places the window on top of the write cell, which shows whether the write pointer skips reserved cells and whether it returns to them after release. Two back-to-back triggers are used in two ways. With the latency changed between them, they test queue ordering and the timing of the latency update. With a fixed latency, the windows overlap and the second trigger must be dropped. Eight spaced triggers followed by a ninth separate the full-queue drop from normal acceptance.

// File: rtl/pipe_cell_ctrl.sv
module pipe_cell_ctrl #(
  parameter int NCELL   = 144,
  parameter int WIN     = 5,
  parameter int QDEPTH  = 8,
  parameter int TAGW    = 12,
  parameter int LATW    = 7,
  parameter int LAT_RST = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [LATW-1:0]          cfg_lat,
  input  logic                     l1a,
  input  logic                     rd_done,
  output logic [$clog2(NCELL)-1:0] wr_cell,
  output logic                     rd_valid,
  output logic [$clog2(NCELL)-1:0] rd_cell,
  output logic [TAGW-1:0]          rd_tag,
  output logic                     rd_last,
  output logic                     ovf,
  output logic                     err
);
  localparam int AW = $clog2(NCELL);
  localparam int QW = $clog2(QDEPTH);
  localparam int KW = (WIN > 1) ? $clog2(WIN) : 1;

  function automatic logic [AW-1:0] cadd(input logic [AW-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    if (s >= NCELL) s -= NCELL;
    return AW'(s);
  endfunction

  logic [LATW-1:0] lat_a, lat_b, lat_c, lat;
  logic [AW-1:0]   wr, wr_nxt, st;
  logic [NCELL-1:0] busy, wmask, rmask, occ;
  logic [TAGW-1:0] bcnt;
  logic [AW-1:0]   q_start [QDEPTH];
  logic [TAGW-1:0] q_tag   [QDEPTH];
  logic [QW:0]     head, iss, tail;
  logic [KW-1:0]   wk;
  logic            win_hit, full, pend, rel, accept;

  assign lat    = (lat_a & lat_b) | (lat_a & lat_c) | (lat_b & lat_c);
  assign st     = cadd(wr, NCELL - int'(lat));
  assign full   = (tail - head) == (QW+1)'(QDEPTH);
  assign pend   = iss != tail;
  assign rel    = rd_done && (head != iss);
  assign accept = l1a && !full && !win_hit;
  assign occ    = busy | (accept ? wmask : '0);

  always_comb begin
    wmask   = '0;
    rmask   = '0;
    win_hit = 1'b0;
    for (int j = 0; j < WIN; j++) begin
      wmask[cadd(st, j)] = 1'b1;
      rmask[cadd(q_start[head[QW-1:0]], j)] = 1'b1;
      win_hit |= busy[cadd(st, j)];
    end
  end

  always_comb begin
    wr_nxt = cadd(wr, 1);
    for (int k = NCELL - 1; k >= 1; k--)
      if (!occ[cadd(wr, k)]) wr_nxt = cadd(wr, k);
  end

  assign wr_cell  = wr;
  assign rd_valid = pend;
  assign rd_cell  = cadd(q_start[iss[QW-1:0]], int'(wk));
  assign rd_tag   = q_tag[iss[QW-1:0]];
  assign rd_last  = pend && (wk == KW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= LATW'(LAT_RST);
      lat_b <= LATW'(LAT_RST);
      lat_c <= LATW'(LAT_RST);
      wr    <= '0;
      bcnt  <= '0;
      busy  <= '0;
      head  <= '0;
      iss   <= '0;
      tail  <= '0;
      wk    <= '0;
      ovf   <= 1'b0;
      err   <= 1'b0;
    end else begin
      lat_a <= cfg_we ? cfg_lat : lat;
      lat_b <= cfg_we ? cfg_lat : lat;
      lat_c <= cfg_we ? cfg_lat : lat;
      wr    <= wr_nxt;
      bcnt  <= bcnt + 1'b1;
      busy  <= (busy & ~(rel ? rmask : '0)) | (accept ? wmask : '0);
      if (accept) begin
        q_start[tail[QW-1:0]] <= st;
        q_tag[tail[QW-1:0]]   <= bcnt;
        tail <= tail + 1'b1;
      end
      if (l1a && !accept) ovf <= 1'b1;
      if (pend) begin
        if (rd_last) begin
          wk  <= '0;
          iss <= iss + 1'b1;
        end else begin
          wk <= wk + 1'b1;
        end
      end
      if (rd_done) begin
        if (rel) head <= head + 1'b1;
        else     err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pipe_cell_ctrl_chk.sv
module pipe_cell_ctrl_chk #(
  parameter int NCELL  = 144,
  parameter int WIN    = 5,
  parameter int QDEPTH = 8,
  parameter int TAGW   = 12,
  parameter int AW     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    wr_cell,
  input logic             rd_valid,
  input logic [AW-1:0]    rd_cell,
  input logic [TAGW-1:0]  rd_tag,
  input logic             rd_last,
  input logic             ovf,
  input logic             err,
  input logic [NCELL-1:0] busy
);
  logic live = 1'b0;
  logic [NCELL-1:0] busy_q;
  always_ff @(posedge clk) begin
    live   <= !rst;
    busy_q <= busy;
  end

  assert_wr_range_R2: assert property (@(posedge clk) disable iff (rst)
    live |-> int'(wr_cell) < NCELL);
  assert_wr_moves_R2: assert property (@(posedge clk) disable iff (rst)
    live |-> wr_cell != $past(wr_cell));
  assert_skip_busy_R5: assert property (@(posedge clk) disable iff (rst)
    live |-> !busy_q[wr_cell]);
  assert_rd_range_R4: assert property (@(posedge clk) disable iff (rst)
    live && rd_valid |-> int'(rd_cell) < NCELL);
  assert_rd_step_R4: assert property (@(posedge clk) disable iff (rst)
    live && rd_valid && !rd_last |=> rd_valid && $stable(rd_tag) &&
      (rd_cell == ((int'($past(rd_cell)) + 1 == NCELL) ? '0 : $past(rd_cell) + 1'b1)));
  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
    live |-> $countones(busy) <= WIN * QDEPTH);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    live && $past(ovf) |-> ovf);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    live && $past(err) |-> err);
endmodule

bind pipe_cell_ctrl pipe_cell_ctrl_chk #(
  .NCELL(NCELL), .WIN(WIN), .QDEPTH(QDEPTH), .TAGW(TAGW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .wr_cell(wr_cell), .rd_valid(rd_valid),
  .rd_cell(rd_cell), .rd_tag(rd_tag), .rd_last(rd_last),
  .ovf(ovf), .err(err), .busy(busy)
);

// File: tb/pipe_cell_ctrl_tb.sv
module pipe_cell_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_lat = '0;
  logic l1a = 1'b0;
  logic rd_done = 1'b0;
  logic [7:0] wr_cell, rd_cell;
  logic rd_valid, rd_last, ovf, err;
  logic [11:0] rd_tag;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pipe_cell_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lat(cfg_lat), .l1a(l1a),
    .rd_done(rd_done), .wr_cell(wr_cell), .rd_valid(rd_valid),
    .rd_cell(rd_cell), .rd_tag(rd_tag), .rd_last(rd_last),
    .ovf(ovf), .err(err)
  );

  // {latency, crossings after reset, expected write cell, expected start, expected tag}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{100,  120, 120,  20,  120},
    '{ 10,    3,   3, 137,    3},
    '{127,  130, 130,   3,  130},
    '{  5,  143, 143, 138,  143},
    '{  2,  143, 143, 141,  143},
    '{100, 4100,  68, 112,    4},
    '{ 64,  200,  56, 136,  200}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_lat(int v);
    cfg_we = 1'b1;
    cfg_lat = 7'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig_stream(string req, int start, int tag);
    l1a = 1'b1;
    @(negedge clk);
    l1a = 1'b0;
    for (int j = 0; j < 5; j++) begin
      chk({req, " valid"}, int'(rd_valid), 1);
      chk({req, " cell"}, int'(rd_cell), (start + j) % 144);
      chk({req, " tag"}, int'(rd_tag), tag);
      chk({req, " last"}, int'(rd_last), (j == 4) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " idle after event"}, int'(rd_valid), 0);
  endtask

  task automatic wait_wr(int v);
    for (int n = 0; n < 300 && int'(wr_cell) != v; n++) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 wr_cell", int'(wr_cell), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 err", int'(err), 0);
    // R9 unmatched readout-done
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    @(negedge clk);
    chk("R9 err set", int'(err), 1);
    chk("R9 no read", int'(rd_valid), 0);
    chk("R2 wr keeps counting", int'(wr_cell), 2);

    // R3 R4 R2: table of windows
    for (int v = 0; v < NV; v++) begin
      do_reset();
      set_lat(VEC[v][0]);
      repeat (VEC[v][1] - 1) @(negedge clk);
      chk("R2 wr before trigger", int'(wr_cell), VEC[v][2]);
      trig_stream("R3 R4 window", VEC[v][3], VEC[v][4]);
      chk("R8 no ovf on accept", int'(ovf), 0);
    end

    // R1 default latency 100
    do_reset();
    repeat (120) @(negedge clk);
    trig_stream("R1 default latency", 20, 120);

    // R5 R6 skip reserved cells, release after readout-done
    do_reset();
    set_lat(0);
    repeat (49) @(negedge clk);
    chk("R5 wr at trigger", int'(wr_cell), 50);
    trig_stream("R5 window on write cell", 50, 50);
    chk("R5 wr jumped", int'(wr_cell), 60);
    wait_wr(49);
    @(negedge clk);
    chk("R6 still reserved", int'(wr_cell), 55);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    wait_wr(49);
    @(negedge clk);
    chk("R6 released", int'(wr_cell), 50);
    chk("R6 no err", int'(err), 0);

    // R7 R3 back-to-back triggers with latency change on the first edge
    do_reset();
    set_lat(20);
    repeat (29) @(negedge clk);
    l1a = 1'b1;
    cfg_we = 1'b1;
    cfg_lat = 7'd60;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R7 first cell", int'(rd_cell), 10);
    chk("R7 first tag", int'(rd_tag), 30);
    @(negedge clk);
    l1a = 1'b0;
    for (int j = 1; j < 10; j++) begin
      chk("R7 valid", int'(rd_valid), 1);
      chk("R7 order cell", int'(rd_cell), (j < 5) ? 10 + j : 115 + j - 5);
      chk("R7 order tag", int'(rd_tag), (j < 5) ? 30 : 31);
      chk("R7 last", int'(rd_last), (j == 4 || j == 9) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7 drained", int'(rd_valid), 0);
    chk("R8 no ovf", int'(ovf), 0);

    // R8 overlapping window dropped
    do_reset();
    set_lat(20);
    repeat (39) @(negedge clk);
    l1a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    l1a = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 overlap only one event", int'(rd_valid), 0);
    chk("R8 overlap ovf", int'(ovf), 1);

    // R8 R7 queue full, then R9 drain
    do_reset();
    set_lat(20);
    repeat (29) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R7 wr spacing", int'(wr_cell), 30 + 6 * i);
      trig_stream("R7 held event", 10 + 6 * i, 30 + 6 * i);
    end
    chk("R8 eight held no ovf", int'(ovf), 0);
    l1a = 1'b1;
    @(negedge clk);
    l1a = 1'b0;
    chk("R8 full dropped", int'(rd_valid), 0);
    chk("R8 full ovf", int'(ovf), 1);
    for (int i = 0; i < 8; i++) begin
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      @(negedge clk);
    end
    chk("R9 matched releases no err", int'(err), 0);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    @(negedge clk);
    chk("R9 extra release err", int'(err), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule